// File: doc/BRIEF.md
# Multi-Channel Compare-Match Timer Core

An up-counting timer whose count advances on a prescaled tick. A three-bit selector picks the tick source. One code takes a bus-rate tick enable, one takes a slow low-rate tick enable, and every other code stops the count. A programmable divider passes one source tick out of every (prescale + 1). The divider restarts from zero whenever software writes the prescale value, so the first period after a write has its full length.

The count is watched by several compare channels. When an advance lands the count on a compare value, that channel's sticky flag sets. When the count advances out of its maximum value, the rollover flag sets. In restart mode, compare channel 1 serves as the period: the tick that follows a count equal to it returns the count to zero. In free-run mode, channel 1 is an ordinary compare and the count wraps at its maximum. One level interrupt is raised while the timer is enabled and any flag has its enable set. Software clears flags with a write-one-to-clear strobe.

Top module: `cmpTimerCore`

## Requirements
- R1: The count resets to 0 and changes only on a prescaled advance, by exactly +1 (or to 0 as described in R4 and R5).
- R2: With a constant source tick, one advance occurs every (prescale + 1) source ticks; prescale is 12 bits wide.
- R3: `srcSel` = 3'b001 takes ticks from `busTick`, 3'b100 from `slowTick`; every other code, including 3'b000, gives no ticks and the count holds.
- R4: In restart mode (`freeRun` = 0), an advance while the count equals compare channel 1 (`cmpVal[CNT_W-1:0]`) returns the count to 0.
- R5: In free-run mode (`freeRun` = 1), compare channel 1 does not reset the count; it runs to all ones and then wraps to 0.
- R6: An advance taken while the count is all ones sets the rollover flag `flags[NUM_CMP]`.
- R7: An advance whose new count equals compare value n (n = 1..NUM_CMP, field `cmpVal[n*CNT_W-1 -: CNT_W]`) sets `flags[n-1]`; channels holding equal values set in the same cycle.
- R8: `irq` is high exactly when `enable` is 1 and `flags & intEn` is nonzero (`intEn` bit positions match `flags`).
- R9: Flags are sticky until a 1 on the same bit of `flagClr`; a new event in the clearing cycle wins and leaves the flag set.
- R10: A 1 on `prescaleWr` restarts the divider from zero and suppresses any advance in that cycle.
- R11: While `enable` is 0, the count and the divider are frozen.
- R12: After reset, count, flags and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Timer run enable; also gates the interrupt |
| freeRun | input | 1 | 1 = free-run wrap, 0 = restart on compare channel 1 |
| srcSel | input | 3 | Tick source select (001 bus, 100 slow, others off) |
| busTick | input | 1 | Bus-rate tick enable |
| slowTick | input | 1 | Slow clock tick enable |
| prescale | input | PS_W | Divider value; period is prescale + 1 source ticks |
| prescaleWr | input | 1 | Strobe marking a write of the prescale value |
| cmpVal | input | NUM_CMP*CNT_W | Compare values, channel 1 in the low field |
| intEn | input | NUM_CMP+1 | Per-flag interrupt enables |
| flagClr | input | NUM_CMP+1 | Write-one-to-clear flag strobes |
| count | output | CNT_W | Live count |
| flags | output | NUM_CMP+1 | Compare flags, rollover in the top bit |
| irq | output | 1 | Level interrupt |

## Verification
The bench drives the count across its full range at a reduced width, so the wrap out of all ones is reached. A design that wrapped early, or that did not set the rollover flag, shows a wrong count or a missing flag there. Restart mode is checked at the period value: an off-by-one period shows up as a count of 13 or a missed return to zero. Two compare channels are given the same value to catch a priority encoder that sets only one flag. A clear is issued in the very cycle a new match lands, which exposes designs where the clear wins. A prescale write is placed in the middle of a divider period to catch a divider that keeps its old phase or lets an advance through on the write cycle.

// File: rtl/cmpTimerPkg.sv
`timescale 1ns/1ps
package cmpTimerPkg;
  // Source select codes the core responds to; all others stop the count.
  localparam logic [2:0] SRC_BUS  = 3'b001;
  localparam logic [2:0] SRC_SLOW = 3'b100;

  // Strobes from control to datapath.
  typedef struct packed {
    logic step;    // advance the count this cycle
    logic toZero;  // the advance returns the count to zero (restart mode)
  } cntCmdT;
endpackage

// File: rtl/cmpTimerCtrl.sv
`timescale 1ns/1ps
module cmpTimerCtrl
  import cmpTimerPkg::*;
#(
  parameter int PS_W = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            freeRun,
  input  logic [2:0]      srcSel,
  input  logic            busTick,
  input  logic            slowTick,
  input  logic [PS_W-1:0] prescale,
  input  logic            prescaleWr,
  input  logic            atPeriod,
  output cntCmdT          cmd
);
  logic            srcTick;
  logic            tickEn;
  logic            psDone;
  logic [PS_W-1:0] psCnt;

  always_comb begin
    unique case (srcSel)
      SRC_BUS:  srcTick = busTick;
      SRC_SLOW: srcTick = slowTick;
      default:  srcTick = 1'b0;
    endcase
  end

  assign tickEn = enable && srcTick && !prescaleWr;
  assign psDone = (psCnt >= prescale);

  always_ff @(posedge clk) begin
    if (!rstN)           psCnt <= '0;
    else if (prescaleWr) psCnt <= '0;
    else if (tickEn)     psCnt <= psDone ? '0 : psCnt + 1'b1;
  end

  always_comb begin
    cmd.step   = tickEn && psDone;
    cmd.toZero = tickEn && psDone && !freeRun && atPeriod;
  end
endmodule

// File: rtl/cmpTimerDatapath.sv
`timescale 1ns/1ps
module cmpTimerDatapath
  import cmpTimerPkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_CMP = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     enable,
  input  cntCmdT                   cmd,
  input  logic [NUM_CMP*CNT_W-1:0] cmpVal,
  input  logic [NUM_CMP:0]         intEn,
  input  logic [NUM_CMP:0]         flagClr,
  output logic [CNT_W-1:0]         count,
  output logic [NUM_CMP:0]         flags,
  output logic                     irq,
  output logic                     atPeriod
);
  localparam int FLAG_W = NUM_CMP + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]  nextCnt;
  logic [FLAG_W-1:0] hitVec;

  assign nextCnt  = cmd.toZero ? '0 : count + 1'b1;
  assign atPeriod = (count == cmpVal[CNT_W-1:0]);

  for (genvar ch = 0; ch < NUM_CMP; ch++) begin : g_cmp
    assign hitVec[ch] = cmd.step && (nextCnt == cmpVal[ch*CNT_W +: CNT_W]);
  end
  assign hitVec[NUM_CMP] = cmd.step && (count == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      flags <= '0;
    end else begin
      if (cmd.step) count <= nextCnt;
      flags <= (flags & ~flagClr) | hitVec;
    end
  end

  assign irq = enable && |(flags & intEn);
endmodule

// File: rtl/cmpTimerCore.sv
`timescale 1ns/1ps
module cmpTimerCore
  import cmpTimerPkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int PS_W    = 12,
  parameter int NUM_CMP = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     enable,
  input  logic                     freeRun,
  input  logic [2:0]               srcSel,
  input  logic                     busTick,
  input  logic                     slowTick,
  input  logic [PS_W-1:0]          prescale,
  input  logic                     prescaleWr,
  input  logic [NUM_CMP*CNT_W-1:0] cmpVal,
  input  logic [NUM_CMP:0]         intEn,
  input  logic [NUM_CMP:0]         flagClr,
  output logic [CNT_W-1:0]         count,
  output logic [NUM_CMP:0]         flags,
  output logic                     irq
);
  cntCmdT cmd;
  logic   atPeriod;

  cmpTimerCtrl #(.PS_W(PS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .freeRun(freeRun),
    .srcSel(srcSel), .busTick(busTick), .slowTick(slowTick),
    .prescale(prescale), .prescaleWr(prescaleWr), .atPeriod(atPeriod),
    .cmd(cmd)
  );

  cmpTimerDatapath #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_dp (
    .clk(clk), .rstN(rstN), .enable(enable), .cmd(cmd),
    .cmpVal(cmpVal), .intEn(intEn), .flagClr(flagClr),
    .count(count), .flags(flags), .irq(irq), .atPeriod(atPeriod)
  );
endmodule

// File: rtl/cmpTimerChecker.sv
`timescale 1ns/1ps
module cmpTimerChecker #(
  parameter int CNT_W   = 32,
  parameter int NUM_CMP = 3
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     enable,
  input logic                     freeRun,
  input logic [2:0]               srcSel,
  input logic                     prescaleWr,
  input logic [NUM_CMP*CNT_W-1:0] cmpVal,
  input logic [NUM_CMP:0]         intEn,
  input logic [NUM_CMP:0]         flagClr,
  input logic [CNT_W-1:0]         count,
  input logic [NUM_CMP:0]         flags,
  input logic                     irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (count == $past(count) || count == $past(count) + 1'b1 || count == '0)); // R1
  AST_NO_SOURCE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel != 3'b001 && srcSel != 3'b100) |=> $stable(count)); // R3
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!freeRun && count == cmpVal[CNT_W-1:0]) |=> (count == '0 || $stable(count))); // R4
  AST_FREE_NO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (freeRun && count != CNT_MAX && count != '0) |=> (count != '0)); // R5
  AST_ROLL_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (count == CNT_MAX) |=> (count != '0 || flags[NUM_CMP])); // R6
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !irq); // R8
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ((flags & intEn) == '0) |-> !irq); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flags & $past(flags & ~flagClr)) == $past(flags & ~flagClr))); // R9
  AST_WRITE_NO_STEP: assert property (@(posedge clk) disable iff (!rstN)
    prescaleWr |=> $stable(count)); // R10
  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> $stable(count)); // R11
endmodule

bind cmpTimerCore cmpTimerChecker #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .freeRun(freeRun), .srcSel(srcSel),
  .prescaleWr(prescaleWr), .cmpVal(cmpVal), .intEn(intEn), .flagClr(flagClr),
  .count(count), .flags(flags), .irq(irq)
);

// File: tb/test_cmpTimerCore.sv
`timescale 1ns/1ps
module test_cmpTimerCore;
  localparam int CW = 8;
  localparam int PW = 12;
  localparam int NC = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          enable = 1'b0, freeRun = 1'b1;
  logic [2:0]    srcSel = 3'b000;
  logic          busTick = 1'b0, slowTick = 1'b0;
  logic [PW-1:0] prescale = '0;
  logic          prescaleWr = 1'b0;
  logic [NC*CW-1:0] cmpVal = '1;
  logic [NC:0]   intEn = '0, flagClr = '0;
  logic [CW-1:0] count;
  logic [NC:0]   flags;
  logic          irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit monOn = 1'b0;

  always #10 clk = ~clk;

  cmpTimerCore #(.CNT_W(CW), .PS_W(PW), .NUM_CMP(NC)) i_cmpTimerCore (
    .clk(clk), .rstN(rstN), .enable(enable), .freeRun(freeRun),
    .srcSel(srcSel), .busTick(busTick), .slowTick(slowTick),
    .prescale(prescale), .prescaleWr(prescaleWr), .cmpVal(cmpVal),
    .intEn(intEn), .flagClr(flagClr), .count(count), .flags(flags), .irq(irq)
  );

  // Expected-state model built from the requirements.
  logic [CW-1:0] mCnt;
  logic [PW-1:0] mPs;
  logic [NC:0]   mFlags;

  function automatic logic srcOn(input logic [2:0] s, input logic b, input logic w);
    return (s == 3'b001 && b) || (s == 3'b100 && w);
  endfunction

  function automatic logic expIrq(input logic en, input logic [NC:0] f, input logic [NC:0] e);
    return en && ((f & e) != '0);
  endfunction

  always @(posedge clk) begin
    logic adv;
    logic [CW-1:0] nxt;
    logic [NC:0] setV;
    if (!rstN) begin
      mCnt = '0; mPs = '0; mFlags = '0;
    end else begin
      adv = 1'b0; setV = '0;
      if (prescaleWr) mPs = '0;
      else if (enable && srcOn(srcSel, busTick, slowTick)) begin
        if (mPs >= prescale) begin mPs = '0; adv = 1'b1; end
        else mPs = mPs + 1'b1;
      end
      if (adv) begin
        nxt = (!freeRun && mCnt == cmpVal[CW-1:0]) ? '0 : mCnt + 1'b1;
        for (int n = 0; n < NC; n++) setV[n] = (nxt == cmpVal[n*CW +: CW]);
        setV[NC] = (mCnt == '1);
        mCnt = nxt;
      end
      mFlags = (mFlags & ~flagClr) | setV;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Cycle monitor against the model, sampled well after the stimulus edge.
  always @(negedge clk) begin
    if (monOn && rstN) begin
      #2;
      chk("R1 count vs model", 32'(count), 32'(mCnt));
      chk("R7 flags vs model", 32'(flags), 32'(mFlags));
      chk("R8 irq vs model", 32'(irq), 32'(expIrq(enable, mFlags, intEn)));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R12: reset state
    chk("R12 count after reset", 32'(count), 0);
    chk("R12 flags after reset", 32'(flags), 0);
    chk("R12 irq after reset", 32'(irq), 0);
    monOn = 1'b1;

    // R2: divide by 3 after a prescale write
    enable = 1; srcSel = 3'b001; busTick = 1; prescale = 2; prescaleWr = 1;
    cyc(1); prescaleWr = 0;
    cyc(9);
    chk("R2 three advances in nine ticks", 32'(count), 3);

    // R10: write mid-period restarts the divider
    cyc(2); prescaleWr = 1; cyc(1); prescaleWr = 0; cyc(2);
    chk("R10 divider restarted, no advance", 32'(count), 3);
    cyc(1);
    chk("R10 advance after full period", 32'(count), 4);

    // R3: unused codes hold the count
    srcSel = 3'b101; slowTick = 1; cyc(10);
    chk("R3 code 101 holds", 32'(count), 4);
    srcSel = 3'b000; cyc(5);
    chk("R3 code 000 holds", 32'(count), 4);
    srcSel = 3'b100; busTick = 0; prescale = 0; prescaleWr = 1; cyc(1); prescaleWr = 0;
    cyc(5);
    chk("R3 slow source counts", 32'(count), 9);

    // R4: restart at compare channel 1 = 12
    freeRun = 0; cmpVal[CW-1:0] = 8'd12; intEn = 4'b0001;
    cyc(3);
    chk("R4 reached period", 32'(count), 12);
    chk("R7 channel 1 flag", 32'(flags), 32'h1);
    chk("R8 irq raised", 32'(irq), 1);
    cyc(1);
    chk("R4 returned to zero", 32'(count), 0);

    // R9: clear, then clear colliding with a new match
    flagClr = 4'b0001; cyc(1); flagClr = '0;
    chk("R9 flag cleared", 32'(flags), 0);
    chk("R8 irq low after clear", 32'(irq), 0);
    cmpVal[CW +: CW] = 8'd3; cyc(1);
    flagClr = 4'b0010; cyc(1); flagClr = '0;
    chk("R9 new match beats clear", 32'(flags), 32'h2);

    // R5, R6, R7: free-run past channel 1, equal compares, wrap
    freeRun = 1; cmpVal[CW-1:0] = 8'd100; cmpVal[2*CW +: CW] = 8'd100;
    flagClr = 4'hF; cyc(1); flagClr = '0;
    cyc(251);
    chk("R5 free-run reached max", 32'(count), 255);
    chk("R7 equal compares both set", 32'(flags), 32'h5);
    cyc(1);
    chk("R5 wrapped to zero", 32'(count), 0);
    chk("R6 rollover flag", 32'(flags), 32'hD);

    // R11: disabled freezes count, irq gated
    enable = 0; cyc(5);
    chk("R11 frozen while disabled", 32'(count), 0);
    chk("R8 irq gated by enable", 32'(irq), 0);
    enable = 1;

    // Random phase
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      case ($urandom_range(0, 5))
        0: srcSel = 3'b000;
        1, 2: srcSel = 3'b001;
        3, 4: srcSel = 3'b100;
        default: srcSel = 3'($urandom_range(0, 7));
      endcase
      busTick  = ($urandom_range(0, 3) != 0);
      slowTick = ($urandom_range(0, 1) != 0);
      enable   = ($urandom_range(0, 15) != 0);
      prescaleWr = ($urandom_range(0, 63) == 0);
      if (prescaleWr) prescale = PW'($urandom_range(0, 3));
      if ($urandom_range(0, 63) == 0) freeRun = ~freeRun;
      if ($urandom_range(0, 127) == 0) cmpVal[$urandom_range(0, NC-1)*CW +: CW] = CW'($urandom);
      if ($urandom_range(0, 31) == 0) intEn = 4'($urandom);
      flagClr = ($urandom_range(0, 7) == 0) ? 4'($urandom) : '0;
    end
    @(negedge clk);
    finishRun();
  end
endmodule